// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a physical address by walking a radix tree of translation tables held in memory. A root input gives the physical address of the top table. The walker reads one 64-bit entry per level through a request/response memory port and follows each valid pointer down to the leaf. It then returns either the physical page joined with the page offset, or a fault that gives the cause and the level where the walk stopped.

On the way down, the walker narrows the permissions granted by each entry it passes. A supervisor-only, read-only or no-execute marking at any level therefore applies to every page beneath that entry. If an entry the walk uses has its accessed flag clear, the walker writes the entry back with the flag set. On a write access it also sets the dirty flag in the leaf. Each of these write-backs completes before the next level is read. The walker handles one translation at a time and waits as long as memory needs to answer.

Top module: `pt_walker`

## Requirements
- R1: After reset `reqReady` is 1, `memReqValid` is 0 and `doneValid` is 0. A request is taken only when `reqReady` is 1. `reqReady` stays 0 from acceptance until after the `doneValid` cycle.
- R2: Level 3 is the top level and level 0 is the leaf. The index for level L is `reqVa[12+9L +: 9]`. Each entry read goes to `{tablePage, index, 3'b000}`. The first table page is `rootAddr[51:12]`, and each later table page is bits 51:12 of the entry read at the level above.
- R3: While `memReqValid` is 1 and `memReqReady` is 0, the request keeps `memReqValid` high and holds its address, direction and write data unchanged.
- R4: Only one memory transaction is outstanding. After a request handshake, no further request is raised until `memRspValid` has returned, whatever the latency. Writes are acknowledged with `memRspValid` too.
- R5: An entry whose bit 0 (present) is 0 ends the walk with a fault. `faultCause` is 0 and `faultLevel` is that entry's level. No write is issued for that entry.
- R6: Access codes are 0 for read, 1 for write and 2 for instruction fetch. A protection fault (`faultCause` = 1) occurs in three cases: a user access (`reqUser` = 1) meets bit 2 = 0 at any level so far; a write meets bit 1 = 0 at any level so far; a fetch meets bit 63 = 1 at any level so far. The reported level is the first level at which the combined permissions deny the access.
- R7: If an entry passes both checks and its bit 5 (accessed) is 0, the walker writes the entry back with bit 5 set to the same address, before reading the next level or finishing. No write is issued when the bit is already set.
- R8: On a write access, the leaf's write-back also sets bit 6 (dirty). On a read or a fetch, bit 6 is left unchanged. A leaf with both bits already set gets no write.
- R9: A walk that succeeds gives one `doneValid` cycle with `doneFault` = 0 and `donePa = {leaf bits 51:12, reqVa[11:0]}`.
- R10: On a fault, `faultVa` and `faultAccess` equal the virtual address and access code of the request.
- R11: In an entry whose present bit is 0, no other bit has any effect. Memory is left untouched and the fault is of the not-present kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rootAddr | input | 52 | Physical address of the top-level table |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVa | input | 48 | Virtual address to translate |
| reqAccess | input | 2 | 0 read, 1 write, 2 fetch |
| reqUser | input | 1 | 1 for a user-level access |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory takes the request |
| memReqWrite | output | 1 | 1 write, 0 read |
| memReqAddr | output | 52 | Byte address of the entry |
| memReqWdata | output | 64 | Entry value to write |
| memRspValid | input | 1 | Read data or write acknowledge |
| memRspData | input | 64 | Read data |
| doneValid | output | 1 | One-cycle completion pulse |
| doneFault | output | 1 | Walk ended in a fault |
| donePa | output | 52 | Translated physical address |
| faultCause | output | 1 | 0 not present, 1 protection |
| faultLevel | output | 2 | Level of the faulting entry |
| faultVa | output | 48 | Virtual address of the walk |
| faultAccess | output | 2 | Access code of the walk |

## Verification
The hardest case to reach from the ports is a protection fault that first appears at an upper level. It has to combine with accessed or dirty write-backs already made at the levels above it, and with memory that stalls both the request and the response. The bench rebuilds a four-page table chain before every walk. Each level's present, permission and status bits come from a pseudo-random stream, and every unused slot is filled with non-present junk. The walk runs under random ready and latency. The full memory image is then compared with a shadow copy that the bench updated under the rules stated in the requirements.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // entry bit positions (decoded by the walker and by software)
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_ACC     = 5;
  localparam int BIT_DIRTY   = 6;
  localparam int BIT_NOEXEC  = 63;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_CHECK, S_WB_REQ, S_WB_WAIT, S_FIN
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic latchEntry;
    logic markEntry;
    logic descend;
    logic setFault;
    logic setDone;
  } dpCtl_t;

  // decisions from datapath to control
  typedef struct packed {
    logic notPresent;
    logic protFault;
    logic needWb;
    logic atLeaf;
  } dpStat_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  dpStat_t stat,
  output logic    reqReady,
  output logic    memReqValid,
  output logic    memReqWrite,
  output logic    doneValid,
  output dpCtl_t  ctl
);

  walkState_t stateQ, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    stateNxt    = stateQ;
    ctl         = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    doneValid   = 1'b0;
    case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capture = 1'b1;
          stateNxt    = S_RD_REQ;
        end
      end
      S_RD_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNxt = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        if (memRspValid) begin
          ctl.latchEntry = 1'b1;
          stateNxt       = S_CHECK;
        end
      end
      S_CHECK: begin
        if (stat.notPresent || stat.protFault) begin
          ctl.setFault = 1'b1;
          stateNxt     = S_FIN;
        end else if (stat.needWb) begin
          stateNxt = S_WB_REQ;
        end else if (stat.atLeaf) begin
          ctl.setDone = 1'b1;
          stateNxt    = S_FIN;
        end else begin
          ctl.descend = 1'b1;
          stateNxt    = S_RD_REQ;
        end
      end
      S_WB_REQ: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) stateNxt = S_WB_WAIT;
      end
      S_WB_WAIT: begin
        if (memRspValid) begin
          ctl.markEntry = 1'b1;
          stateNxt      = S_CHECK;
        end
      end
      S_FIN: begin
        doneValid = 1'b1;
        stateNxt  = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int OFS_W   = 12,
  parameter int IDX_W   = 9,
  parameter int LEVELS  = 4,
  parameter int ENTRY_W = 64,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int PPN_W  = PA_W - OFS_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [PA_W-1:0]    rootAddr,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [1:0]         reqAccess,
  input  logic               reqUser,
  input  logic [ENTRY_W-1:0] memRspData,
  output dpStat_t            stat,
  output logic [PA_W-1:0]    memReqAddr,
  output logic [ENTRY_W-1:0] memReqWdata,
  output logic               doneFault,
  output logic [PA_W-1:0]    donePa,
  output logic               faultCause,
  output logic [LVL_W-1:0]   faultLevel,
  output logic [VA_W-1:0]    faultVa,
  output logic [1:0]         faultAccess
);

  localparam int SLOT_W = OFS_W - IDX_W;

  logic [VA_W-1:0]    vaQ;
  logic [1:0]         accQ;
  logic               userQ;
  logic [LVL_W-1:0]   levelQ;
  logic [PPN_W-1:0]   basePpn;
  logic [ENTRY_W-1:0] entryQ;
  logic               permWrQ, permUsQ, noExecQ;
  logic               faultQ, causeQ;
  logic [LVL_W-1:0]   faultLvlQ;
  logic [PA_W-1:0]    paQ;

  // per-level index fields
  logic [IDX_W-1:0] idxOf [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxOf[g] = vaQ[OFS_W + g*IDX_W +: IDX_W];
  end

  logic [IDX_W-1:0]   curIdx;
  logic               effWr, effUs, effNx;
  logic [ENTRY_W-1:0] wbData;

  always_comb begin
    curIdx = idxOf[levelQ];
    effWr  = permWrQ & entryQ[BIT_WRITE];
    effUs  = permUsQ & entryQ[BIT_USER];
    effNx  = noExecQ | entryQ[BIT_NOEXEC];
    wbData = entryQ;
    wbData[BIT_ACC] = 1'b1;
    if (levelQ == '0 && accQ == ACC_WRITE) wbData[BIT_DIRTY] = 1'b1;
    stat.notPresent = !entryQ[BIT_PRESENT];
    stat.protFault  = (userQ && !effUs) ||
                      (accQ == ACC_WRITE && !effWr) ||
                      (accQ == ACC_FETCH && effNx);
    stat.needWb     = (wbData != entryQ);
    stat.atLeaf     = (levelQ == '0);
  end

  assign memReqAddr  = {basePpn, curIdx, {SLOT_W{1'b0}}};
  assign memReqWdata = wbData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ       <= '0;
      accQ      <= '0;
      userQ     <= 1'b0;
      levelQ    <= '0;
      basePpn   <= '0;
      entryQ    <= '0;
      permWrQ   <= 1'b1;
      permUsQ   <= 1'b1;
      noExecQ   <= 1'b0;
      faultQ    <= 1'b0;
      causeQ    <= 1'b0;
      faultLvlQ <= '0;
      paQ       <= '0;
    end else begin
      if (ctl.capture) begin
        vaQ     <= reqVa;
        accQ    <= reqAccess;
        userQ   <= reqUser;
        levelQ  <= LVL_W'(LEVELS - 1);
        basePpn <= rootAddr[PA_W-1:OFS_W];
        permWrQ <= 1'b1;
        permUsQ <= 1'b1;
        noExecQ <= 1'b0;
        faultQ  <= 1'b0;
        causeQ  <= 1'b0;
        paQ     <= '0;
      end
      if (ctl.latchEntry) entryQ <= memRspData;
      if (ctl.markEntry)  entryQ <= wbData;
      if (ctl.descend) begin
        basePpn <= entryQ[PA_W-1:OFS_W];
        levelQ  <= levelQ - 1'b1;
        permWrQ <= effWr;
        permUsQ <= effUs;
        noExecQ <= effNx;
      end
      if (ctl.setFault) begin
        faultQ    <= 1'b1;
        causeQ    <= !stat.notPresent;
        faultLvlQ <= levelQ;
      end
      if (ctl.setDone) paQ <= {entryQ[PA_W-1:OFS_W], vaQ[OFS_W-1:0]};
    end
  end

  assign doneFault   = faultQ;
  assign donePa      = paQ;
  assign faultCause  = causeQ;
  assign faultLevel  = faultLvlQ;
  assign faultVa     = vaQ;
  assign faultAccess = accQ;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int OFS_W   = 12,
  parameter int IDX_W   = 9,
  parameter int LEVELS  = 4,
  parameter int ENTRY_W = 64,
  localparam int LVL_W  = $clog2(LEVELS)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PA_W-1:0]    rootAddr,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [1:0]         reqAccess,
  input  logic               reqUser,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic               memReqWrite,
  output logic [PA_W-1:0]    memReqAddr,
  output logic [ENTRY_W-1:0] memReqWdata,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               doneValid,
  output logic               doneFault,
  output logic [PA_W-1:0]    donePa,
  output logic               faultCause,
  output logic [LVL_W-1:0]   faultLevel,
  output logic [VA_W-1:0]    faultVa,
  output logic [1:0]         faultAccess
);

  dpCtl_t  ctl;
  dpStat_t stat;

  pt_walker_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .stat(stat), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .doneValid(doneValid), .ctl(ctl)
  );

  pt_walker_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .ENTRY_W(ENTRY_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rootAddr(rootAddr), .reqVa(reqVa),
    .reqAccess(reqAccess), .reqUser(reqUser), .memRspData(memRspData),
    .stat(stat), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .doneFault(doneFault), .donePa(donePa), .faultCause(faultCause),
    .faultLevel(faultLevel), .faultVa(faultVa), .faultAccess(faultAccess)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W    = 52,
  parameter int ENTRY_W = 64
)(
  input logic               clk,
  input logic               rstN,
  input logic               reqReady,
  input logic               memReqValid,
  input logic               memReqReady,
  input logic               memReqWrite,
  input logic [PA_W-1:0]    memReqAddr,
  input logic [ENTRY_W-1:0] memReqWdata,
  input logic               memRspValid,
  input logic               doneValid
);

  logic            outstanding;
  logic [PA_W-1:0] lastRdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      lastRdAddr  <= '0;
    end else begin
      if (memReqValid && memReqReady) outstanding <= 1'b1;
      else if (memRspValid)           outstanding <= 1'b0;
      if (memReqValid && memReqReady && !memReqWrite) lastRdAddr <= memReqAddr;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReqValid && !doneValid));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr) &&
      $stable(memReqWrite) && $stable(memReqWdata)));

  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !memReqValid);

  p_wb_same_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> (memReqAddr == lastRdAddr && memReqWdata[5]));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .ENTRY_W(ENTRY_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqWrite(memReqWrite),
  .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
  .memRspValid(memRspValid), .doneValid(doneValid)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [51:0] rootAddr = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVa = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic        memReqWrite;
  logic [51:0] memReqAddr;
  logic [63:0] memReqWdata;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        doneValid, doneFault, faultCause;
  logic [51:0] donePa;
  logic [1:0]  faultLevel, faultAccess;
  logic [47:0] faultVa;

  always #2 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN), .rootAddr(rootAddr), .reqValid(reqValid),
    .reqReady(reqReady), .reqVa(reqVa), .reqAccess(reqAccess),
    .reqUser(reqUser), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memRspValid(memRspValid),
    .memRspData(memRspData), .doneValid(doneValid), .doneFault(doneFault),
    .donePa(donePa), .faultCause(faultCause), .faultLevel(faultLevel),
    .faultVa(faultVa), .faultAccess(faultAccess)
  );

  int tests = 0, fails = 0;
  int cycles = 0;
  bit timedOut = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  logic [63:0] mem    [0:2047];
  logic [63:0] shadow [0:2047];

  int  memWrites = 0, addrErr = 0, holdErr = 0, overlapErr = 0;
  bit  pending = 1'b0;
  int  latCnt = 0;
  logic [63:0] pendData = '0;
  bit  prevWait = 1'b0;
  logic [51:0] prevAddr = '0;
  logic [63:0] prevWdata = '0;
  logic        prevWrite = 1'b0;

  function automatic logic [31:0] nextRnd(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic rnd(output logic [31:0] v);
    seed = nextRnd(seed);
    v = seed;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) timedOut <= 1'b1;
  end

  // memory model: decisions at the falling edge
  initial begin
    forever begin
      logic [31:0] r;
      @(negedge clk);
      memRspValid = 1'b0;
      if (prevWait) begin
        if (!memReqValid || memReqAddr != prevAddr || memReqWrite != prevWrite ||
            memReqWdata != prevWdata) holdErr++;
      end
      if (pending) begin
        if (memReqValid) overlapErr++;
        if (latCnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = pendData;
          pending     = 1'b0;
        end else latCnt--;
        memReqReady = 1'b0;
      end else begin
        rnd(r);
        memReqReady = r[0] | r[1];
        if (memReqValid && memReqReady) begin
          if (memReqAddr[51:14] != '0 || memReqAddr[2:0] != 3'd0) addrErr++;
          if (memReqWrite) begin
            mem[memReqAddr[13:3]] = memReqWdata;
            memWrites++;
            pendData = '0;
          end else pendData = mem[memReqAddr[13:3]];
          pending = 1'b1;
          latCnt  = int'(r[5:4]);
        end
      end
      prevWait  = memReqValid && !memReqReady;
      prevAddr  = memReqAddr;
      prevWrite = memReqWrite;
      prevWdata = memReqWdata;
    end
  end

  // reference from the requirements, applied to the shadow copy
  task automatic refWalk(input logic [47:0] va, input logic [1:0] acc,
                         input bit usr, output bit flt, output bit cause,
                         output logic [1:0] lvl, output logic [51:0] pa,
                         output int nWr);
    logic [39:0] page = rootAddr[51:12];
    bit wr = 1'b1, us = 1'b1, nx = 1'b0;
    flt = 1'b0; cause = 1'b0; lvl = '0; pa = '0; nWr = 0;
    for (int L = 3; L >= 0; L--) begin
      int          ix = int'(page[1:0]) * 512 + int'(va[12 + 9*L +: 9]);
      logic [63:0] e  = shadow[ix];
      logic [63:0] n;
      if (!e[0]) begin flt = 1'b1; cause = 1'b0; lvl = 2'(L); return; end
      wr &= e[1]; us &= e[2]; nx |= e[63];
      if ((usr && !us) || (acc == 2'd1 && !wr) || (acc == 2'd2 && nx)) begin
        flt = 1'b1; cause = 1'b1; lvl = 2'(L); return;
      end
      n = e | 64'h20;
      if (L == 0 && acc == 2'd1) n |= 64'h40;
      if (n != e) begin shadow[ix] = n; nWr++; end
      page = e[51:12];
    end
    pa = {page, va[11:0]};
  endtask

  task automatic buildTables(input int k, input logic [47:0] va,
                             input logic [39:0] leafPpn);
    logic [31:0] r, r2;
    for (int i = 0; i < 2048; i++) begin
      rnd(r); rnd(r2);
      mem[i] = {r2, r} & ~64'h1;
    end
    for (int L = 3; L >= 0; L--) begin
      logic [63:0] e;
      rnd(r); rnd(r2);
      e = {r2, r};
      e[51:12] = (L > 0) ? 40'(4 - L) : leafPpn;
      e[0] = (r[31:28] != 4'd0);
      e[1] = (r[27:25] % 5 != 0);
      e[2] = (r[24:22] % 5 != 0);
      e[63] = (r2[31:29] % 6 == 0);
      if (k == 0) begin e[0] = 1; e[1] = 1; e[2] = 1; e[63] = 0; e[5] = 1; e[6] = 1; end
      if (k == 1) begin e[0] = 1; e[1] = 1; e[2] = 1; e[63] = 0; e[5] = 0; e[6] = 0; end
      if (k == 2 && L == 3) e = 64'hFFFF_FFFF_FFFF_FFFE;
      mem[(3 - L) * 512 + int'(va[12 + 9*L +: 9])] = e;
    end
  endtask

  task automatic runWalk(input int k);
    logic [31:0] r, r2;
    logic [47:0] va;
    logic [1:0]  acc;
    bit          usr, eFlt, eCause;
    logic [1:0]  eLvl;
    logic [51:0] ePa;
    int          eWr, w0, diff;
    rnd(r); rnd(r2);
    va  = {r2[15:0], r};
    acc = 2'(k % 3);
    usr = (k % 2) == 1;
    if (k == 0 || k == 1) begin acc = 2'd1; usr = 1'b1; end
    rnd(r); rnd(r2);
    buildTables(k, va, {r2[7:0], r});
    for (int i = 0; i < 2048; i++) shadow[i] = mem[i];
    refWalk(va, acc, usr, eFlt, eCause, eLvl, ePa, eWr);
    w0 = memWrites;
    while (!reqReady && !timedOut) @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqAccess = acc; reqUser = usr;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R1 busy after accept", 64'(reqReady), 0);
    while (!doneValid && !timedOut) @(negedge clk);
    if (timedOut) return;
    check(doneFault == eFlt, "R5/R6 fault flag", 64'(doneFault), 64'(eFlt));
    if (eFlt) begin
      check(faultCause == eCause, eCause ? "R6 cause" : "R5 cause",
            64'(faultCause), 64'(eCause));
      check(faultLevel == eLvl, eCause ? "R6 level" : "R5 level",
            64'(faultLevel), 64'(eLvl));
      check(faultVa == va && faultAccess == acc, "R10 fault va/access",
            64'(faultVa), 64'(va));
      if (k == 2) check(memWrites == w0, "R11 no write on absent entry",
                        64'(memWrites - w0), 0);
    end else
      check(donePa == ePa, "R9 R2 physical address", 64'(donePa), 64'(ePa));
    diff = 0;
    for (int i = 0; i < 2048; i++) if (mem[i] != shadow[i]) diff++;
    check(diff == 0, "R7 R8 memory image", 64'(diff), 0);
    check(memWrites - w0 == eWr, "R7 write-back count", 64'(memWrites - w0), 64'(eWr));
    if (k == 0) check(memWrites == w0, "R8 no write when A and D set", 64'(memWrites - w0), 0);
    if (k == 1) check(memWrites - w0 == 4, "R7 R8 four write-backs", 64'(memWrites - w0), 4);
    @(negedge clk);
    check(doneValid == 1'b0 && reqReady == 1'b1, "R9 single done pulse",
          64'(doneValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && memReqValid == 1'b0 && doneValid == 1'b0,
          "R1 reset state", {61'd0, reqReady, memReqValid, doneValid}, 64'h4);
    rstN = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 400 && !timedOut; k++) runWalk(k);
    check(addrErr == 0, "R2 entry address alignment/range", 64'(addrErr), 0);
    check(holdErr == 0, "R3 request held under stall", 64'(holdErr), 0);
    check(overlapErr == 0, "R4 single outstanding", 64'(overlapErr), 0);
    if (timedOut) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule